// File: doc/BRIEF.md
# Configurable Output Register Macrocell Bank

This block is the output stage that sits behind a programmable logic plane. Each cell takes one data sum term and one enable/clock sum term and turns them into a pin value and feedback for the plane. Per-cell configuration selects one of three behaviours: plain combinational pass-through, a D register that loads on a rising edge of the E term, or a D register on the shared clock that loads only while the E term is true. Two programmable inversions are available per cell, one on the E term and one on the pin output. The pin output stage is inverting, so a cleared register shows as a high pin.

All registers share an active-high clear term that acts without a clock, and a power-up reset that does the same. A test preload writes any value straight into the registers on the shared clock. It outranks normal loading and yields to the clear. Each cell drives a tri-state pad, given as a data/enable pair, under its own output-enable term. It returns two feedbacks: the core value before the pin buffer, and the value seen through the pin input path. Cells marked as buried by a parameter never drive their pad. They still pass the pad input back, so the pin stays usable as an input, and they supply the complement of the core value in place of an output inversion.

The private-clock mode is built inside one synchronous clock domain. The E term is sampled on the shared clock, and its rising edge acts as the load strobe.

Top module: `mcell_bank`

## Requirements
- R1: While `rst_n` is low every register reads 0. A registered cell whose pad is enabled and whose output inversion bit is 0 therefore drives `pin_out` = 1.
- R2: Mode codes 2'b00 and 2'b11 are combinational. `fb_core` follows `d_term` in the same cycle, and neither the clear term nor preload changes it.
- R3: Mode 2'b10 is clock-enable. On a shared clock edge the register loads `d_term` when the effective E term is 1 and holds its value when it is 0.
- R4: Mode 2'b01 is sum-term clock. The register loads `d_term` on a shared clock edge where the effective E term is 1 and was 0 at the previous edge. After power-up the previous value counts as 1, so the E term must first be seen low.
- R5: The effective E term is `e_term` XOR `cfg_e_inv`.
- R6: For a pin cell, `pin_out` = NOT(core XOR `cfg_out_inv`), where core is the register in modes 2'b01 and 2'b10 and `d_term` otherwise.
- R7: `ar_term` = 1 clears every register to 0 at once, with no clock edge needed. It outranks preload.
- R8: `pre_en` = 1 loads `pre_val` into every register on the next shared clock edge in any mode, taking priority over clock-enable and edge loads.
- R9: For a pin cell, `pin_oe` equals `oe_term`. `fb_pin` equals `pin_out` while `pin_oe` is 1 and `pin_in` while it is 0.
- R10: `fb_core` carries the core value whatever the state of `oe_term`, and `fb_core_n` is always its complement.
- R11: A cell whose `BURIED_MASK` bit is 1 keeps `pin_oe` = 0 and `pin_out` = 1, ignores `cfg_out_inv` and `oe_term`, and passes `pin_in` to `fb_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared output clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| cfg_mode | input | 2*NC | Mode per cell, bits [2i+1:2i] for cell i |
| cfg_out_inv | input | NC | Output inversion bit per cell |
| cfg_e_inv | input | NC | E-term inversion bit per cell |
| d_term | input | NC | Data sum term per cell |
| e_term | input | NC | Enable/clock sum term per cell |
| oe_term | input | NC | Output-enable product term per cell |
| ar_term | input | 1 | Common asynchronous clear term, active high |
| pre_en | input | 1 | Test preload strobe |
| pre_val | input | NC | Preload value per cell |
| pin_in | input | NC | Value sensed at each pad |
| pin_out | output | NC | Pad drive value |
| pin_oe | output | NC | Pad driver enable |
| fb_core | output | NC | Feedback taken before the pin buffer |
| fb_core_n | output | NC | Complement of fb_core |
| fb_pin | output | NC | Feedback through the pin input path |

## Verification
The interesting collisions are the clear term against a preload, and a preload against a clock-enable or edge load, all at the same shared clock edge. The bench raises `ar_term` and `pre_en` together and expects 0 in every register. It also raises `pre_en` while the E term would load `d_term`, with `pre_val` and `d_term` set to opposite values, and expects `pre_val`. A random phase reaches both collisions repeatedly, and a reference model written from the priority order judges each cycle.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_STCLK = 2'b01,
    MODE_CE    = 2'b10,
    MODE_COMB2 = 2'b11
  } mode_e;

  // Inverting pad buffer after the polarity XOR
  function automatic logic pin_level(logic core, logic inv);
    return ~(core ^ inv);
  endfunction

  function automatic logic is_registered(logic [1:0] m);
    return (m == MODE_STCLK) || (m == MODE_CE);
  endfunction

  // Load strobe of the normal (non-preload) path
  function automatic logic load_fire(logic [1:0] m, logic e_now, logic e_rise);
    return ((m == MODE_CE) && e_now) || ((m == MODE_STCLK) && e_rise);
  endfunction

endpackage

// File: rtl/mcell_eterm.sv
module mcell_eterm (
  input  logic clk,
  input  logic rst_n,
  input  logic e_term,
  input  logic e_inv,
  output logic e_eff,
  output logic e_rise
);
  logic e_last;

  assign e_eff  = e_term ^ e_inv;
  assign e_rise = e_eff & ~e_last;

  // Starts high so a term already true after power-up gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_last <= 1'b1;
    else        e_last <= e_eff;
  end
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] mode,
  input  logic       d,
  input  logic       e_eff,
  input  logic       e_rise,
  input  logic       pre_en,
  input  logic       pre_val,
  output logic       q,
  output logic       core
);
  logic load;

  assign load = load_fire(mode, e_eff, e_rise);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)         q <= 1'b0;
    else if (pre_en) q <= pre_val;
    else if (load)   q <= d;
  end

  assign core = is_registered(mode) ? q : d;
endmodule

// File: rtl/mcell_pad.sv
module mcell_pad
  import mcell_pkg::*;
#(
  parameter bit BURIED = 1'b0
) (
  input  logic core,
  input  logic out_inv,
  input  logic oe,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_pin
);
  generate
    if (BURIED) begin : g_buried
      logic unused_pad;
      assign unused_pad = ^{core, out_inv, oe};
      assign pin_oe  = 1'b0;
      assign pin_out = 1'b1;
      assign fb_pin  = pin_in;
    end else begin : g_pin
      assign pin_oe  = oe;
      assign pin_out = pin_level(core, out_inv);
      assign fb_pin  = oe ? pin_out : pin_in;
    end
  endgenerate
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank
  import mcell_pkg::*;
#(
  parameter int          NC          = 4,
  parameter logic [NC-1:0] BURIED_MASK = 4'b1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NC-1:0] cfg_mode,
  input  logic [NC-1:0]   cfg_out_inv,
  input  logic [NC-1:0]   cfg_e_inv,
  input  logic [NC-1:0]   d_term,
  input  logic [NC-1:0]   e_term,
  input  logic [NC-1:0]   oe_term,
  input  logic            ar_term,
  input  logic            pre_en,
  input  logic [NC-1:0]   pre_val,
  input  logic [NC-1:0]   pin_in,
  output logic [NC-1:0]   pin_out,
  output logic [NC-1:0]   pin_oe,
  output logic [NC-1:0]   fb_core,
  output logic [NC-1:0]   fb_core_n,
  output logic [NC-1:0]   fb_pin
);
  localparam int MW = 2;

  // Named internal events for the checker
  logic          clr;
  logic [NC-1:0] q_int;
  logic [NC-1:0] e_eff_int;
  logic [NC-1:0] e_rise_int;
  logic [NC-1:0] core_int;

  assign clr = ar_term | ~rst_n;

  generate
    for (genvar i = 0; i < NC; i++) begin : g_cell
      mcell_eterm u_eterm (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_term (e_term[i]),
        .e_inv  (cfg_e_inv[i]),
        .e_eff  (e_eff_int[i]),
        .e_rise (e_rise_int[i])
      );

      mcell_reg u_reg (
        .clk     (clk),
        .clr     (clr),
        .mode    (cfg_mode[MW*i +: MW]),
        .d       (d_term[i]),
        .e_eff   (e_eff_int[i]),
        .e_rise  (e_rise_int[i]),
        .pre_en  (pre_en),
        .pre_val (pre_val[i]),
        .q       (q_int[i]),
        .core    (core_int[i])
      );

      mcell_pad #(.BURIED(BURIED_MASK[i])) u_pad (
        .core    (core_int[i]),
        .out_inv (cfg_out_inv[i]),
        .oe      (oe_term[i]),
        .pin_in  (pin_in[i]),
        .pin_out (pin_out[i]),
        .pin_oe  (pin_oe[i]),
        .fb_pin  (fb_pin[i])
      );
    end
  endgenerate

  assign fb_core   = core_int;
  assign fb_core_n = ~core_int;
endmodule

// File: rtl/mcell_bank_chk.sv
module mcell_bank_chk #(
  parameter int            NC          = 4,
  parameter logic [NC-1:0] BURIED_MASK = 4'b1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ar_term,
  input logic            pre_en,
  input logic [NC-1:0]   pre_val,
  input logic [2*NC-1:0] cfg_mode,
  input logic [NC-1:0]   d_term,
  input logic [NC-1:0]   e_eff,
  input logic [NC-1:0]   q,
  input logic [NC-1:0]   pin_out,
  input logic [NC-1:0]   pin_oe,
  input logic [NC-1:0]   pin_in,
  input logic [NC-1:0]   fb_pin,
  input logic [NC-1:0]   fb_core,
  input logic [NC-1:0]   fb_core_n
);
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    ar_term |-> (q == '0));

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    fb_core_n == ~fb_core);

  generate
    for (genvar i = 0; i < NC; i++) begin : g_chk
      a_r3_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_term && !pre_en && cfg_mode[2*i +: 2] == 2'b10 && !e_eff[i])
        |=> (ar_term || q[i] == $past(q[i])));

      a_r8_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_term && pre_en) |=> (ar_term || q[i] == $past(pre_val[i])));

      a_r2_comb_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[2*i +: 2] == 2'b00 || cfg_mode[2*i +: 2] == 2'b11)
        |-> fb_core[i] == d_term[i]);

      a_r9_fb_driven: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[i] |-> fb_pin[i] == pin_out[i]);

      a_r9_fb_sensed: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[i] |-> fb_pin[i] == pin_in[i]);

      if (BURIED_MASK[i]) begin : g_bur
        a_r11_buried_quiet: assert property (@(posedge clk) disable iff (!rst_n)
          !pin_oe[i] && pin_out[i]);
      end
    end
  endgenerate
endmodule

bind mcell_bank mcell_bank_chk #(.NC(NC), .BURIED_MASK(BURIED_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ar_term   (ar_term),
  .pre_en    (pre_en),
  .pre_val   (pre_val),
  .cfg_mode  (cfg_mode),
  .d_term    (d_term),
  .e_eff     (e_eff_int),
  .q         (q_int),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_in    (pin_in),
  .fb_pin    (fb_pin),
  .fb_core   (fb_core),
  .fb_core_n (fb_core_n)
);

// File: tb/mcell_bank_bench.sv
`timescale 1ns/1ps
module mcell_bank_bench;
  localparam int NC = 4;
  localparam logic [NC-1:0] BUR = 4'b1000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NC-1:0] cfg_mode = '0;
  logic [NC-1:0]   cfg_out_inv = '0, cfg_e_inv = '0;
  logic [NC-1:0]   d_term = '0, e_term = '0, oe_term = '0;
  logic            ar_term = 1'b0, pre_en = 1'b0;
  logic [NC-1:0]   pre_val = '0, pin_in = '0;
  logic [NC-1:0]   pin_out, pin_oe, fb_core, fb_core_n, fb_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NC-1:0] po, poe, fbc, fbcn, fbp;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference state
  bit m_q [NC];
  bit m_ep[NC];

  always #10 clk = ~clk;

  mcell_bank #(.NC(NC), .BURIED_MASK(BUR)) u_mcell_bank (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_out_inv(cfg_out_inv),
    .cfg_e_inv(cfg_e_inv), .d_term(d_term), .e_term(e_term), .oe_term(oe_term),
    .ar_term(ar_term), .pre_en(pre_en), .pre_val(pre_val), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_core(fb_core), .fb_core_n(fb_core_n),
    .fb_pin(fb_pin)
  );

  // Monitor: pops one expectation per edge that has one
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (pin_out !== it.po || pin_oe !== it.poe || fb_core !== it.fbc ||
          fb_core_n !== it.fbcn || fb_pin !== it.fbp) begin
        errors++;
        $display("FAIL %s: got po=%b oe=%b fbc=%b fbcn=%b fbp=%b exp po=%b oe=%b fbc=%b fbcn=%b fbp=%b",
                 it.tag, pin_out, pin_oe, fb_core, fb_core_n, fb_pin,
                 it.po, it.poe, it.fbc, it.fbcn, it.fbp);
      end
    end
  end

  // Driver: inputs already set after a negedge; model the coming edge
  task automatic step(string tag);
    exp_t it;
    for (int i = 0; i < NC; i++) begin
      bit e, core, b;
      logic [1:0] m;
      m = cfg_mode[2*i +: 2];
      e = e_term[i] ^ cfg_e_inv[i];               // R5
      if (!rst_n) begin m_q[i] = 0; m_ep[i] = 1; end // R1, R4
      else begin
        if (ar_term)                       m_q[i] = 0;          // R7
        else if (pre_en)                   m_q[i] = pre_val[i]; // R8
        else if (m == 2'b10 && e)          m_q[i] = d_term[i];  // R3
        else if (m == 2'b01 && e && !m_ep[i]) m_q[i] = d_term[i]; // R4
        m_ep[i] = e;
      end
      core = (m == 2'b01 || m == 2'b10) ? m_q[i] : d_term[i];  // R2
      b = BUR[i];
      it.poe[i]  = oe_term[i] & ~b;                             // R9, R11
      it.po[i]   = b ? 1'b1 : ~(core ^ cfg_out_inv[i]);         // R6
      it.fbc[i]  = core;                                        // R10
      it.fbcn[i] = ~core;
      it.fbp[i]  = it.poe[i] ? it.po[i] : pin_in[i];
    end
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic direct(string tag, logic [NC-1:0] got, logic [NC-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // cell0 CE, cell1 STCLK, cell2 comb, cell3 CE buried
    cfg_mode = {2'b10, 2'b00, 2'b01, 2'b10};
    oe_term  = 4'b1111;
    d_term   = 4'b1111;
    e_term   = 4'b1111;
    @(negedge clk);
    step("R1 reset");
    step("R1 reset hold");
    rst_n = 1'b1;
    d_term = 4'b0000; e_term = 4'b0000;
    step("R1 after release");
    // R3 clock enable load then hold
    d_term = 4'b1111; e_term = 4'b0001;
    step("R3 load");
    d_term = 4'b0000; e_term = 4'b0000;
    step("R3 hold");
    step("R3 hold again");
    // R4 edge load
    d_term = 4'b0010; e_term = 4'b0010;
    step("R4 rising edge");
    d_term = 4'b0000;
    step("R4 level held no reload");
    e_term = 4'b0000;
    step("R4 falling");
    e_term = 4'b0010;
    step("R4 second edge loads 0");
    // R5 inverted E
    cfg_e_inv = 4'b0001; e_term = 4'b0000; d_term = 4'b0000;
    step("R5 inverted enable loads");
    e_term = 4'b0001; d_term = 4'b0001;
    step("R5 inverted enable holds");
    // R6 output inversion, R11 buried ignores it
    cfg_out_inv = 4'b1111;
    step("R6 R11 polarity");
    cfg_out_inv = 4'b0000; cfg_e_inv = 4'b0000;
    // R8 preload beats clock enable
    e_term = 4'b1001; d_term = 4'b1001; pre_en = 1'b1; pre_val = 4'b0110;
    step("R8 preload over load");
    pre_en = 1'b0; e_term = 4'b0000;
    step("R8 preload held");
    // R7 async clear, direct mid-cycle check then collision with preload
    e_term = 4'b0001; d_term = 4'b0001;
    step("R3 set cell0");
    ar_term = 1'b1;
    #1 direct("R7 async clear", fb_core & 4'b1011, 4'b0000);
    pre_en = 1'b1; pre_val = 4'b1111;
    step("R7 clear beats preload");
    ar_term = 1'b0; pre_en = 1'b0; e_term = 4'b0000;
    // R2 comb mode 11, ignores clear
    cfg_mode[5:4] = 2'b11; d_term = 4'b0100; ar_term = 1'b1;
    step("R2 mode 11 follows d");
    ar_term = 1'b0; d_term = 4'b0000;
    step("R2 mode 11 low");
    // R9 pad disabled, R11 buried passes pin_in
    oe_term = 4'b0000; pin_in = 4'b1010;
    step("R9 R11 pin sensed");
    pin_in = 4'b0101; oe_term = 4'b1111;
    step("R9 driven feedback");
    // mixed random phase
    for (int k = 0; k < 400; k++) begin
      cfg_mode    = 8'($urandom);
      cfg_out_inv = 4'($urandom);
      cfg_e_inv   = 4'($urandom);
      d_term      = 4'($urandom);
      e_term      = 4'($urandom);
      oe_term     = 4'($urandom);
      pin_in      = 4'($urandom);
      pre_val     = 4'($urandom);
      pre_en      = ($urandom % 6) == 0;
      ar_term     = ($urandom % 9) == 0;
      step("MIX");
    end
    ar_term = 1'b0; pre_en = 1'b0;
    @(posedge clk); #5;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule